// File: doc/BRIEF.md
# Four-Entry Flow Classifier CAM

This block classifies packets into flows. Each lookup presents a 112-bit key made up of packet header fields. The key is compared in parallel against four programmable entries. Each entry stores a key pattern and a 16-bit flow identifier. If one or more entries hold the key, the identifier of the lowest-numbered of them is returned. If none does, the block returns a 16-bit hash instead. The hash is formed by XOR-folding the key, so unmatched traffic still gets a pseudo-unique flow number. The match vector and the hash are also presented on their own outputs.

The entries are written through a single control-word port. One 128-bit word carries both the key pattern and the flow identifier, and an index picks which of the four entries it lands in. The same port can remove an entry, so that it no longer matches anything.

The result stage is a three-state machine:
- ST_IDLE: no result this cycle.
- ST_HIT: a result in which at least one entry matched.
- ST_MISS: a result in which no entry matched.

Its transitions run every cycle:
- Any state goes to ST_HIT on a lookup strobe whose key matches.
- Any state goes to ST_MISS on a lookup strobe whose key does not match.
- Any state goes to ST_IDLE when there is no strobe.
- Reset forces ST_IDLE.

Top module: `flow_cam_classifier`

## Requirements
- R1: A synchronous active-low reset clears all four entries to empty and forces ST_IDLE. While reset is applied and after it, res_valid, res_hit, res_vec, res_flow and res_hash are all zero until the first lookup. A lookup on the freshly reset table misses.
- R2: res_valid is high exactly in the cycle after a cycle with lk_req high, and low otherwise. res_vec, res_flow and res_hash change only after a strobe and hold their values between strobes.
- R3: res_vec bit i is 1 when entry i is occupied and its stored key equals the key strobed one cycle earlier. res_hit is 1 in a result cycle exactly when res_vec is nonzero, and 0 in all other cycles.
- R4: When several entries match, res_flow carries the flow identifier of the lowest-numbered matching entry.
- R5: res_hash is the XOR of the seven 16-bit slices of the strobed key, where slice k is key bits [16k+15:16k].
- R6: On a miss, res_hit is 0 and res_flow equals res_hash.
- R7: A write with wr_en high targets the entry numbered wr_idx (0 to 3, any of them). The stored key is taken from wr_word[127:16] and the flow identifier from wr_word[15:0]. With wr_install=1 the entry becomes occupied. With wr_install=0 it becomes empty and matches nothing.
- R8: A write in cycle N affects lookups strobed in cycle N+1 and later. A lookup strobed in the same cycle N sees the table as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_req | input | 1 | Lookup strobe |
| lk_key | input | 112 | Header key to classify |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 2 | Entry number to write |
| wr_install | input | 1 | 1 installs the entry, 0 removes it |
| wr_word | input | 128 | Control word: key in [127:16], flow ID in [15:0] |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | Result matched at least one entry |
| res_flow | output | 16 | Selected flow ID, or the hash on a miss |
| res_vec | output | 4 | Per-entry match vector |
| res_hash | output | 16 | XOR-folded key hash |

## Verification
The bench loads the same key into several entries at once. A priority encoder that favours the highest index, or one that ORs the identifiers together, then returns the wrong flow. It strobes a lookup in the same cycle as a write to that entry. A table with a bypass path would report a hit one cycle too early. It removes entries and looks up their old keys, which catches a design that clears only the identifier and leaves the entry occupied. Misses on random keys compare res_flow with an independently computed fold. A slice ordering error, or a fallback that returns zero, shows up there at once.

// File: rtl/flow_cls_pkg.sv
package flow_cls_pkg;

    // Result stage states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } res_state_t;

endpackage

// File: rtl/flow_cls_entry.sv
// One table slot: stored key, flow identifier and occupancy, plus its comparator.
module flow_cls_entry #(
    parameter int KEY_W  = 112,
    parameter int FLOW_W = 16,
    parameter int IDX_W  = 2,
    parameter int MY_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_install,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [FLOW_W-1:0] wr_flow,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              hit,
    output logic [FLOW_W-1:0] flow
);

    localparam logic [IDX_W-1:0] SLOT = IDX_W'(MY_IDX);

    logic              occ_q;
    logic [KEY_W-1:0]  key_q;
    logic [FLOW_W-1:0] flow_q;
    logic              sel_w;

    assign sel_w = wr_en && (wr_idx == SLOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= 1'b0;
            key_q  <= '0;
            flow_q <= '0;
        end else if (sel_w) begin
            occ_q  <= wr_install;
            key_q  <= wr_key;
            flow_q <= wr_flow;
        end
    end

    // Compare uses the stored state, so a write only shows on the next cycle.
    assign hit  = occ_q && (key_q == lk_key);
    assign flow = flow_q;

endmodule

// File: rtl/flow_cls_prio.sv
// Lowest-index-wins selection of a flow identifier from the match vector.
module flow_cls_prio #(
    parameter int N      = 4,
    parameter int FLOW_W = 16
) (
    input  logic [N-1:0]        vec,
    input  logic [N*FLOW_W-1:0] flows,
    output logic                any,
    output logic [FLOW_W-1:0]   sel_flow
);

    always_comb begin
        any      = 1'b0;
        sel_flow = '0;
        // Walk from the top down so the lowest matching index is written last.
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any      = 1'b1;
                sel_flow = flows[i*FLOW_W +: FLOW_W];
            end
        end
    end

endmodule

// File: rtl/flow_cls_fold.sv
// XOR-folds a wide key into OUT_W bits, slice by slice from bit 0 upward.
module flow_cls_fold #(
    parameter int KEY_W = 112,
    parameter int OUT_W = 16
) (
    input  logic [KEY_W-1:0] key,
    output logic [OUT_W-1:0] hash
);

    localparam int SLICES = (KEY_W + OUT_W - 1) / OUT_W;
    localparam int PAD_W  = SLICES * OUT_W;

    logic [PAD_W-1:0] padded;

    always_comb begin
        padded             = '0;
        padded[KEY_W-1:0]  = key;
        hash               = '0;
        for (int s = 0; s < SLICES; s++) begin
            hash = hash ^ padded[s*OUT_W +: OUT_W];
        end
    end

endmodule

// File: rtl/flow_cam_classifier.sv
module flow_cam_classifier
    import flow_cls_pkg::*;
#(
    parameter  int NUM_ENTRIES = 4,
    parameter  int KEY_W       = 112,
    parameter  int FLOW_W      = 16,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CTL_W       = KEY_W + FLOW_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_req,
    input  logic [KEY_W-1:0]       lk_key,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_install,
    input  logic [CTL_W-1:0]       wr_word,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [FLOW_W-1:0]      res_flow,
    output logic [NUM_ENTRIES-1:0] res_vec,
    output logic [FLOW_W-1:0]      res_hash
);

    // Control word split: key in the upper part, flow identifier in the low part
    logic [KEY_W-1:0]  wr_key;
    logic [FLOW_W-1:0] wr_flow;

    assign wr_key  = wr_word[CTL_W-1:FLOW_W];
    assign wr_flow = wr_word[FLOW_W-1:0];

    // Table and parallel compare
    logic [NUM_ENTRIES-1:0]        match_vec;
    logic [NUM_ENTRIES*FLOW_W-1:0] flow_bus;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        flow_cls_entry #(
            .KEY_W (KEY_W),
            .FLOW_W(FLOW_W),
            .IDX_W (IDX_W),
            .MY_IDX(g)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_idx    (wr_idx),
            .wr_install(wr_install),
            .wr_key    (wr_key),
            .wr_flow   (wr_flow),
            .lk_key    (lk_key),
            .hit       (match_vec[g]),
            .flow      (flow_bus[g*FLOW_W +: FLOW_W])
        );
    end

    // Priority selection
    logic              any_hit;
    logic [FLOW_W-1:0] sel_flow;

    flow_cls_prio #(
        .N     (NUM_ENTRIES),
        .FLOW_W(FLOW_W)
    ) u_prio (
        .vec     (match_vec),
        .flows   (flow_bus),
        .any     (any_hit),
        .sel_flow(sel_flow)
    );

    // Fallback hash
    logic [FLOW_W-1:0] hash_w;

    flow_cls_fold #(
        .KEY_W(KEY_W),
        .OUT_W(FLOW_W)
    ) u_fold (
        .key (lk_key),
        .hash(hash_w)
    );

    // Result state machine
    res_state_t state_q;
    res_state_t state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (lk_req) begin
            state_d = any_hit ? ST_HIT : ST_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result data registers, loaded only on a strobe
    logic [NUM_ENTRIES-1:0] vec_q;
    logic [FLOW_W-1:0]      flow_q;
    logic [FLOW_W-1:0]      hash_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            flow_q <= '0;
            hash_q <= '0;
        end else if (lk_req) begin
            vec_q  <= match_vec;
            hash_q <= hash_w;
            flow_q <= any_hit ? sel_flow : hash_w;
        end
    end

    // Output decode from the state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                res_valid = 1'b0;
                res_hit   = 1'b0;
            end
            ST_HIT: begin
                res_valid = 1'b1;
                res_hit   = 1'b1;
            end
            ST_MISS: begin
                res_valid = 1'b1;
                res_hit   = 1'b0;
            end
            default: begin
                res_valid = 1'b0;
                res_hit   = 1'b0;
            end
        endcase
    end

    assign res_vec  = vec_q;
    assign res_flow = flow_q;
    assign res_hash = hash_q;

endmodule

// File: rtl/flow_cam_classifier_chk.sv
module flow_cam_classifier_chk #(
    parameter int NUM_ENTRIES = 4,
    parameter int KEY_W       = 112,
    parameter int FLOW_W      = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_req,
    input logic [KEY_W-1:0]       lk_key,
    input logic                   res_valid,
    input logic                   res_hit,
    input logic [FLOW_W-1:0]      res_flow,
    input logic [NUM_ENTRIES-1:0] res_vec,
    input logic [FLOW_W-1:0]      res_hash
);

    // Bitwise fold: output bit b is the parity of key bits whose index is b mod FLOW_W.
    function automatic logic [FLOW_W-1:0] ref_fold(input logic [KEY_W-1:0] k);
        logic [FLOW_W-1:0] r;
        r = '0;
        for (int j = 0; j < KEY_W; j++) begin
            r[j % FLOW_W] = r[j % FLOW_W] ^ k[j];
        end
        return r;
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_hit && res_vec == '0 && res_flow == '0 && res_hash == '0));

    assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_valid);

    assert_no_valid_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !res_valid);

    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> ($stable(res_vec) && $stable(res_flow) && $stable(res_hash)));

    assert_hit_matches_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_valid && res_vec != '0));

    assert_miss_has_no_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_vec == '0));

    assert_hash_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (res_hash == ref_fold($past(lk_key))));

    assert_miss_uses_hash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_flow == res_hash));

endmodule

bind flow_cam_classifier flow_cam_classifier_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .KEY_W      (KEY_W),
    .FLOW_W     (FLOW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_key   (lk_key),
    .res_valid(res_valid),
    .res_hit  (res_hit),
    .res_flow (res_flow),
    .res_vec  (res_vec),
    .res_hash (res_hash)
);

// File: tb/flow_cam_classifier_bench.sv
`timescale 1ns/1ps
module flow_cam_classifier_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_req = 1'b0;
    logic [111:0] lk_key = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_idx = '0;
    logic         wr_install = 1'b0;
    logic [127:0] wr_word = '0;
    logic         res_valid, res_hit;
    logic [15:0]  res_flow, res_hash;
    logic [3:0]   res_vec;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string scen = "R1";

    always #2.5 clk = ~clk;

    flow_cam_classifier u_flow_cam_classifier (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_key(lk_key),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_install(wr_install), .wr_word(wr_word),
        .res_valid(res_valid), .res_hit(res_hit), .res_flow(res_flow),
        .res_vec(res_vec), .res_hash(res_hash)
    );

    // Behavioural reference model
    bit           m_occ  [4];
    logic [111:0] m_key  [4];
    logic [15:0]  m_flow [4];
    bit           e_valid, e_hit;
    logic [3:0]   e_vec;
    logic [15:0]  e_flow, e_hash;

    function automatic logic [15:0] fold(input logic [111:0] k);
        logic [15:0] h = '0;
        for (int s = 0; s < 7; s++) h ^= k[s*16 +: 16];
        return h;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_occ[i] = 0; m_key[i] = '0; m_flow[i] = '0; end
            e_valid = 0; e_hit = 0; e_vec = '0; e_flow = '0; e_hash = '0;
        end else begin
            e_valid = lk_req;
            e_hit   = 0;
            if (lk_req) begin
                int first;
                first = -1;
                for (int i = 0; i < 4; i++) begin
                    e_vec[i] = m_occ[i] && (m_key[i] == lk_key);
                    if (e_vec[i] && first < 0) first = i;
                end
                e_hash = fold(lk_key);
                e_hit  = (first >= 0);
                e_flow = e_hit ? m_flow[first] : e_hash;
            end
            if (wr_en) begin
                m_occ[wr_idx]  = wr_install;
                m_key[wr_idx]  = wr_word[127:16];
                m_flow[wr_idx] = wr_word[15:0];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s [%s] actual=%0h expected=%0h", req, what, scen, act, exp);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk(res_valid == e_valid, "R2", "res_valid", res_valid, e_valid);
            chk(res_hit == e_hit, "R3", "res_hit", res_hit, e_hit);
            chk(res_vec == e_vec, "R3", "res_vec", res_vec, e_vec);
            chk(res_hash == e_hash, "R5", "res_hash", res_hash, e_hash);
            chk(res_flow == e_flow, e_hit ? "R4" : "R6", "res_flow", res_flow, e_flow);
        end
    end

    function automatic logic [111:0] rkey();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic cyc(input bit req, input logic [111:0] k, input bit we, input int idx,
                       input logic [111:0] wk, input logic [15:0] wf, input bit inst);
        @(negedge clk);
        lk_req = req; lk_key = k;
        wr_en = we; wr_idx = idx[1:0]; wr_word = {wk, wf}; wr_install = inst;
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0, '0, '0, 0);
    endtask

    task automatic put(input int idx, input logic [111:0] k, input logic [15:0] f);
        cyc(0, '0, 1, idx, k, f, 1);
    endtask

    // Lookup then explicit check of the named requirement on the next cycle
    task automatic look(input logic [111:0] k, input bit hit, input logic [15:0] f, input string req);
        cyc(1, k, 0, 0, '0, '0, 0);
        idle();
        chk(res_valid && res_hit == hit, req, "hit", res_hit, hit);
        if (hit) chk(res_flow == f, req, "flow", res_flow, f);
    endtask

    logic [111:0] ka, kb, kc, kd, kx;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(res_valid == 0 && res_vec == 0 && res_flow == 0 && res_hash == 0, "R1",
            "reset outputs", {res_valid, res_vec, res_flow, res_hash}, 0);
        rst_n = 1'b1;
        ka = rkey(); kb = rkey(); kc = rkey(); kd = rkey();
        look(ka, 0, 0, "R1");

        // R7: write all four entries, each found by its own key
        scen = "R7";
        put(0, ka, 16'h1000); put(1, kb, 16'h1111); put(2, kc, 16'h2222); put(3, kd, 16'h3333);
        look(ka, 1, 16'h1000, "R7");
        look(kb, 1, 16'h1111, "R7");
        look(kc, 1, 16'h2222, "R7");
        look(kd, 1, 16'h3333, "R7");

        // R4: duplicate keys, lowest index wins
        scen = "R4";
        kx = rkey();
        put(1, kx, 16'hAAA1); put(3, kx, 16'hAAA3);
        look(kx, 1, 16'hAAA1, "R4");
        chk(res_vec == 4'b1010, "R4", "dup vec (bit i = entry i)", res_vec, 4'b1010);
        put(0, kx, 16'hAAA0); put(2, kx, 16'hAAA2);
        look(kx, 1, 16'hAAA0, "R4");
        chk(res_vec == 4'b1111, "R4", "all vec", res_vec, 4'b1111);

        // R6 / R5: misses fall back to the fold
        scen = "R6";
        for (int i = 0; i < 8; i++) begin
            kx = rkey();
            look(kx, 0, 0, "R6");
            chk(res_flow == fold(kx), "R6", "fallback flow", res_flow, fold(kx));
        end
        scen = "R5";
        look({112{1'b1}}, 0, 0, "R5");
        chk(res_hash == 16'hFFFF, "R5", "all-ones fold", res_hash, 16'hFFFF);

        // R8: same-cycle write is not seen, next cycle it is
        scen = "R8";
        kx = rkey();
        cyc(1, kx, 1, 2, kx, 16'h5A5A, 1);
        cyc(1, kx, 0, 0, '0, '0, 0);
        chk(res_valid && !res_hit, "R8", "same-cycle write seen", res_hit, 0);
        idle();
        chk(res_hit && res_flow == 16'h5A5A, "R8", "next-cycle hit", res_flow, 16'h5A5A);

        // R7: removal
        scen = "R7";
        cyc(0, '0, 1, 2, kx, 16'h0, 0);
        look(kx, 0, 0, "R7");

        // R2: hold between strobes
        scen = "R2";
        repeat (5) idle();
        chk(res_valid == 0, "R2", "idle valid", res_valid, 0);

        // Mixed random traffic
        scen = "mix";
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 3);
            kx = (sel == 0) ? rkey() : (sel == 1 ? ka : (sel == 2 ? kb : kd));
            cyc($urandom_range(0, 1), kx, ($urandom_range(0, 3) == 0), $urandom_range(0, 3),
                (($urandom_range(0, 1) == 1) ? kb : ka), 16'($urandom()), $urandom_range(0, 1));
        end
        idle(); idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog [%s] actual=timeout expected=finish", scen);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule